// File: doc/BRIEF.md
# Asynchronous Static Memory Controller

This block runs a single external asynchronous memory port of the NOR-flash or SRAM kind. A host puts one access on a small request interface and holds it for one cycle while the controller is idle. The request carries the address, the bank address, the direction and the write data. It also carries the timing for that access: setup, strobe and hold counts, given separately for reads and for writes. Two more bits come with it: one turns on the external wait input, and one selects select-strobe chip-select behaviour.

The controller takes the memory through three phases: setup, strobe and hold. The strobe is output enable for a read and write enable for a write. When wait handling is on, an active-high wait pin holds the strobe open past its programmed length. The pin is synchronised and filtered first, so the stretch starts and ends at fixed latencies from the pin. At the end of the access, read data is returned together with a done pulse that lasts one cycle.

Top module: `async_sram_ctrl`

## Requirements
- R1: A read with setup count S and hold count H holds chip select low for S+1 cycles before output enable falls, and for H+1 cycles after it rises, when select-strobe mode is off.
- R2: With wait handling off, output enable stays low for exactly T+1 cycles, where T is the read strobe count. Done rises S+T+H+3 cycles after the accepting clock edge.
- R3: A write uses only the write setup, strobe and hold counts. Write enable is low for its strobe count plus one cycle, and the access takes the sum of the three write counts plus 3 cycles. Output enable and write enable are never low together.
- R4: With wait handling on, the strobe is stretched only if the wait pin goes high at least 4 cycles before the edge on which the strobe would normally rise. When stretched, the strobe rises on the 4th clock edge after the pin is seen low, and the hold phase follows.
- R5: A high pulse on the wait pin that lasts a single cycle never stretches an access. A pulse of 2 or more cycles can stretch it.
- R6: With wait handling off, the wait pin has no effect on any phase length.
- R7: Address, bank address and read-not-write (high for reads, low for writes) hold their values from the first setup cycle to the last hold cycle. A request presented during that time does not change them.
- R8: In select-strobe mode, chip select is low only in the cycles in which the strobe is low. The setup and hold lengths still apply.
- R9: Read data is sampled on the clock edge on which output enable rises. It is presented on the read data output in the cycle in which done is high.
- R10: During a write, the controller drives the write data onto the data bus from the first setup cycle to the last hold cycle. The data is already driven in the cycle before write enable falls.
- R11: Ready is high only in idle. Done is high for exactly one cycle per access. A request held high while the controller is busy starts nothing.
- R12: During and straight after reset, chip select, output enable and write enable are high, done is low and ready is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Request strobe, taken when reqReady is high |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W | Access address |
| reqBank | input | BANK_W | Bank address |
| reqWdata | input | DATA_W | Write data |
| rdSetup | input | SETUP_W | Read setup count |
| rdStrobe | input | STROBE_W | Read strobe count |
| rdHold | input | HOLD_W | Read hold count |
| wrSetup | input | SETUP_W | Write setup count |
| wrStrobe | input | STROBE_W | Write strobe count |
| wrHold | input | HOLD_W | Write hold count |
| extWaitEn | input | 1 | Lets the wait pin stretch the strobe |
| selStrobe | input | 1 | Chip select only during the strobe |
| reqReady | output | 1 | Controller idle |
| done | output | 1 | One-cycle completion pulse |
| rdData | output | DATA_W | Captured read data |
| memCsN | output | 1 | Chip select, active low |
| memOeN | output | 1 | Output enable, active low |
| memWeN | output | 1 | Write enable, active low |
| memRnw | output | 1 | Read-not-write |
| memAddr | output | ADDR_W | Memory address |
| memBank | output | BANK_W | Memory bank address |
| memData | inout | DATA_W | Bidirectional memory data |
| memWait | input | 1 | External wait, active high |

## Verification
The case that is hardest to reach from the ports is a wait pulse that lands right at the honouring window. A pin rise three cycles before the normal strobe end must be ignored, and a rise one cycle earlier must be obeyed. A one-cycle pulse must disappear in the filter. To reach these cases, the bench drives the wait pin from the same per-cycle loop that watches the access, placing it at edge offsets from the first strobe cycle. It sweeps the rise offset across the whole strobe window for pulse widths of one, two and four cycles, and predicts each strobe length as the larger of the programmed length and the release offset plus four.

// File: rtl/asc_pkg.sv
package asc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_HOLD
  } phase_e;

  typedef struct packed {
    logic load;      // request taken this cycle
    logic setupPh;   // setup phase active
    logic strobePh;  // strobe phase active
    logic holdPh;    // hold phase active
    logic capture;   // last strobe cycle
  } phaseCtl_t;
endpackage

// File: rtl/asc_wait_filter.sv
module asc_wait_filter (
  input  logic clk,
  input  logic rstN,
  input  logic rawIn,
  output logic filtOut
);
  logic [1:0] syncQ;
  logic       lastQ;
  logic       filtQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncQ <= '0;
      lastQ <= 1'b0;
      filtQ <= 1'b0;
    end else begin
      syncQ <= {syncQ[0], rawIn};
      lastQ <= syncQ[1];
      if (syncQ[1] == lastQ) filtQ <= lastQ;
    end
  end

  assign filtOut = filtQ;

  AST_WAIT_FILTERED: assert property (@(posedge clk) disable iff (!rstN)
    (filtQ != $past(filtQ)) |-> ($past(rawIn, 3) == filtQ && $past(rawIn, 4) == filtQ)); // R5
endmodule

// File: rtl/asc_ctrl.sv
module asc_ctrl
  import asc_pkg::*;
#(
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [SETUP_W-1:0]  rdSetup,
  input  logic [STROBE_W-1:0] rdStrobe,
  input  logic [HOLD_W-1:0]   rdHold,
  input  logic [SETUP_W-1:0]  wrSetup,
  input  logic [STROBE_W-1:0] wrStrobe,
  input  logic [HOLD_W-1:0]   wrHold,
  input  logic                extWaitEn,
  input  logic                waitSeen,
  output logic                reqReady,
  output logic                done,
  output phaseCtl_t           ctl
);
  localparam int SH_W  = (SETUP_W > HOLD_W) ? SETUP_W : HOLD_W;
  localparam int CNT_W = (SH_W > STROBE_W) ? SH_W : STROBE_W;

  phase_e           stateQ;
  logic [CNT_W-1:0] cntQ;
  logic [CNT_W-1:0] strobeLenQ;
  logic [CNT_W-1:0] holdLenQ;
  logic             ewQ;
  logic             doneQ;
  logic             cntZero;
  logic             stretch;

  assign cntZero = (cntQ == '0);
  assign stretch = ewQ && waitSeen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ     <= ST_IDLE;
      cntQ       <= '0;
      strobeLenQ <= '0;
      holdLenQ   <= '0;
      ewQ        <= 1'b0;
      doneQ      <= 1'b0;
    end else begin
      doneQ <= (stateQ == ST_HOLD) && cntZero;
      case (stateQ)
        ST_IDLE: if (reqValid) begin
          stateQ     <= ST_SETUP;
          cntQ       <= CNT_W'(reqWrite ? wrSetup : rdSetup);
          strobeLenQ <= CNT_W'(reqWrite ? wrStrobe : rdStrobe);
          holdLenQ   <= CNT_W'(reqWrite ? wrHold : rdHold);
          ewQ        <= extWaitEn;
        end
        ST_SETUP: begin
          if (cntZero) begin
            stateQ <= ST_STROBE;
            cntQ   <= strobeLenQ;
          end else begin
            cntQ <= cntQ - 1'b1;
          end
        end
        ST_STROBE: begin
          if (!cntZero) begin
            cntQ <= cntQ - 1'b1;
          end else if (!stretch) begin
            stateQ <= ST_HOLD;
            cntQ   <= holdLenQ;
          end
        end
        default: begin
          if (cntZero) stateQ <= ST_IDLE;
          else         cntQ   <= cntQ - 1'b1;
        end
      endcase
    end
  end

  assign reqReady     = (stateQ == ST_IDLE);
  assign done         = doneQ;
  assign ctl.load     = (stateQ == ST_IDLE) && reqValid;
  assign ctl.setupPh  = (stateQ == ST_SETUP);
  assign ctl.strobePh = (stateQ == ST_STROBE);
  assign ctl.holdPh   = (stateQ == ST_HOLD);
  assign ctl.capture  = (stateQ == ST_STROBE) && cntZero && !stretch;

  AST_NO_STRETCH_OFF: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_STROBE && cntZero && !ewQ) |=> (stateQ == ST_HOLD)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    doneQ |=> !doneQ); // R11
  AST_SETUP_FROM_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (stateQ == ST_SETUP && $past(stateQ) != ST_SETUP) |-> ($past(stateQ) == ST_IDLE)); // R11
endmodule

// File: rtl/asc_datapath.sv
module asc_datapath
  import asc_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int BANK_W = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  phaseCtl_t         ctl,
  input  logic              reqWrite,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [BANK_W-1:0] reqBank,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic              selStrobe,
  input  logic [DATA_W-1:0] memDataIn,
  output logic [DATA_W-1:0] rdData,
  output logic              memCsN,
  output logic              memOeN,
  output logic              memWeN,
  output logic              memRnw,
  output logic [ADDR_W-1:0] memAddr,
  output logic [BANK_W-1:0] memBank,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);
  logic [ADDR_W-1:0] addrQ;
  logic [BANK_W-1:0] bankQ;
  logic [DATA_W-1:0] wdataQ;
  logic [DATA_W-1:0] rdDataQ;
  logic              writeQ;
  logic              ssQ;
  logic              busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ   <= '0;
      bankQ   <= '0;
      wdataQ  <= '0;
      rdDataQ <= '0;
      writeQ  <= 1'b0;
      ssQ     <= 1'b0;
    end else begin
      if (ctl.load) begin
        addrQ  <= reqAddr;
        bankQ  <= reqBank;
        wdataQ <= reqWdata;
        writeQ <= reqWrite;
        ssQ    <= selStrobe;
      end
      if (ctl.capture && !writeQ) rdDataQ <= memDataIn;
    end
  end

  assign busy    = ctl.setupPh || ctl.strobePh || ctl.holdPh;
  assign memCsN  = ssQ ? !ctl.strobePh : !busy;
  assign memOeN  = !(ctl.strobePh && !writeQ);
  assign memWeN  = !(ctl.strobePh && writeQ);
  assign memRnw  = !writeQ;
  assign memAddr = addrQ;
  assign memBank = bankQ;
  assign dataOut = wdataQ;
  assign dataOe  = busy && writeQ;
  assign rdData  = rdDataQ;

  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> ($stable(memAddr) && $stable(memBank) && $stable(memRnw))); // R7
  AST_CS_SETUP: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(memOeN) && !ssQ) |-> (!memCsN && !$past(memCsN))); // R1
  AST_SS_CS_ONLY_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    (ssQ && !memCsN) |-> (!memOeN || !memWeN)); // R8
  AST_DATA_BEFORE_WE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(memWeN) |-> (dataOe && $past(dataOe))); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rstN)
    !(!memOeN && !memWeN)); // R3
endmodule

// File: rtl/async_sram_ctrl.sv
module async_sram_ctrl
  import asc_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int BANK_W   = 2,
  parameter int DATA_W   = 16,
  parameter int SETUP_W  = 4,
  parameter int STROBE_W = 6,
  parameter int HOLD_W   = 4
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                reqValid,
  input  logic                reqWrite,
  input  logic [ADDR_W-1:0]   reqAddr,
  input  logic [BANK_W-1:0]   reqBank,
  input  logic [DATA_W-1:0]   reqWdata,
  input  logic [SETUP_W-1:0]  rdSetup,
  input  logic [STROBE_W-1:0] rdStrobe,
  input  logic [HOLD_W-1:0]   rdHold,
  input  logic [SETUP_W-1:0]  wrSetup,
  input  logic [STROBE_W-1:0] wrStrobe,
  input  logic [HOLD_W-1:0]   wrHold,
  input  logic                extWaitEn,
  input  logic                selStrobe,
  output logic                reqReady,
  output logic                done,
  output logic [DATA_W-1:0]   rdData,
  output logic                memCsN,
  output logic                memOeN,
  output logic                memWeN,
  output logic                memRnw,
  output logic [ADDR_W-1:0]   memAddr,
  output logic [BANK_W-1:0]   memBank,
  inout  wire  [DATA_W-1:0]   memData,
  input  logic                memWait
);
  phaseCtl_t         ctl;
  logic              waitSeen;
  logic [DATA_W-1:0] dataOut;
  logic              dataOe;

  asc_wait_filter u_waitFilter (
    .clk     (clk),
    .rstN    (rstN),
    .rawIn   (memWait),
    .filtOut (waitSeen)
  );

  asc_ctrl #(
    .SETUP_W  (SETUP_W),
    .STROBE_W (STROBE_W),
    .HOLD_W   (HOLD_W)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .rdSetup   (rdSetup),
    .rdStrobe  (rdStrobe),
    .rdHold    (rdHold),
    .wrSetup   (wrSetup),
    .wrStrobe  (wrStrobe),
    .wrHold    (wrHold),
    .extWaitEn (extWaitEn),
    .waitSeen  (waitSeen),
    .reqReady  (reqReady),
    .done      (done),
    .ctl       (ctl)
  );

  asc_datapath #(
    .ADDR_W (ADDR_W),
    .BANK_W (BANK_W),
    .DATA_W (DATA_W)
  ) u_datapath (
    .clk       (clk),
    .rstN      (rstN),
    .ctl       (ctl),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqBank   (reqBank),
    .reqWdata  (reqWdata),
    .selStrobe (selStrobe),
    .memDataIn (memData),
    .rdData    (rdData),
    .memCsN    (memCsN),
    .memOeN    (memOeN),
    .memWeN    (memWeN),
    .memRnw    (memRnw),
    .memAddr   (memAddr),
    .memBank   (memBank),
    .dataOut   (dataOut),
    .dataOe    (dataOe)
  );

  assign memData = dataOe ? dataOut : {DATA_W{1'bz}};
endmodule

// File: tb/async_sram_ctrl_bench.sv
module async_sram_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [11:0] reqAddr = '0;
  logic [1:0]  reqBank = '0;
  logic [15:0] reqWdata = '0;
  logic [3:0]  rdSetup = '0, wrSetup = '0, rdHold = '0, wrHold = '0;
  logic [5:0]  rdStrobe = '0, wrStrobe = '0;
  logic        extWaitEn = 1'b0;
  logic        selStrobe = 1'b0;
  logic        memWait = 1'b0;
  logic        reqReady, done, memCsN, memOeN, memWeN, memRnw;
  logic [15:0] rdData;
  logic [11:0] memAddr;
  logic [1:0]  memBank;
  wire  [15:0] memData;
  logic [15:0] model;

  int checkCnt = 0;
  int failCnt = 0;
  int seq = 0;

  always #5 clk = ~clk;

  // memory model: drives the bus while the part is selected and output-enabled
  assign model   = (16'(memAddr) * 16'd37) ^ 16'(memBank);
  assign memData = (!memOeN && !memCsN) ? model : 16'hzzzz;

  async_sram_ctrl u_async_sram_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqBank(reqBank), .reqWdata(reqWdata),
    .rdSetup(rdSetup), .rdStrobe(rdStrobe), .rdHold(rdHold),
    .wrSetup(wrSetup), .wrStrobe(wrStrobe), .wrHold(wrHold),
    .extWaitEn(extWaitEn), .selStrobe(selStrobe),
    .reqReady(reqReady), .done(done), .rdData(rdData),
    .memCsN(memCsN), .memOeN(memOeN), .memWeN(memWeN), .memRnw(memRnw),
    .memAddr(memAddr), .memBank(memBank), .memData(memData), .memWait(memWait)
  );

  task automatic chk(input string tag, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // a/b: wait pin rise/fall as edge offsets from the first strobe edge
  task automatic runAccess(input bit wr, input int rs, input int st, input int rh,
                           input bit ew, input bit ss, input bit useWait,
                           input int a, input int b, input bit intrude,
                           input string stTag);
    int expSt, tTot, n, pre, stb, post, csLow, csBad, addrBad, busBad, readyBad, doneAt;
    bit seen, sLow;
    logic [11:0] ad;
    logic [1:0]  bk;
    logic [15:0] wd, rdCap, rdExp;
    expSt = st + 1;
    if (useWait && ew && (b - a) >= 2 && a <= st - 3 && b + 4 > st + 1) expSt = b + 4;
    tTot = rs + expSt + rh + 2;
    seq++;
    ad = 12'(seq * 97 + 5);
    bk = 2'(seq);
    wd = 16'(seq * 1237 + 3);
    rdExp = (16'(ad) * 16'd37) ^ 16'(bk);
    pre = 0; stb = 0; post = 0; csLow = 0; csBad = 0; addrBad = 0;
    busBad = 0; readyBad = 0; doneAt = 0; seen = 0; n = 0; rdCap = '0;
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqAddr = ad; reqBank = bk; reqWdata = wd;
    extWaitEn = ew; selStrobe = ss;
    if (wr) begin
      wrSetup = 4'(rs); wrStrobe = 6'(st); wrHold = 4'(rh);
      rdSetup = 4'(rs + 3); rdStrobe = 6'(st + 2); rdHold = 4'(rh + 1);
    end else begin
      rdSetup = 4'(rs); rdStrobe = 6'(st); rdHold = 4'(rh);
      wrSetup = 4'(rs + 2); wrStrobe = 6'(st + 3); wrHold = 4'(rh + 2);
    end
    @(posedge clk);
    while (doneAt == 0 && n < tTot + 40) begin
      @(negedge clk);
      n++;
      sLow = wr ? !memWeN : !memOeN;
      if (sLow) begin stb++; seen = 1; end
      else if (!done && !seen) pre++;
      else if (!done && seen) post++;
      if (!memCsN) csLow++;
      if (ss && !memCsN && !sLow) csBad++;
      if (!done) begin
        if (memAddr !== ad || memBank !== bk || memRnw !== !wr) addrBad++;
        if (reqReady) readyBad++;
        if (wr && memData !== wd) busBad++;
      end else begin
        doneAt = n;
        rdCap = rdData;
      end
      reqValid = intrude && !done;
      reqAddr  = intrude ? ~ad : ad;
      memWait  = useWait && n >= rs + 1 + a && n < rs + 1 + b;
    end
    memWait = 1'b0;
    reqValid = 1'b0;
    chk(wr ? "R3 total" : "R2 total", doneAt - 1, tTot);
    chk("R1 setup", pre, rs + 1);
    chk(stTag, stb, expSt);
    chk("R1 hold", post, rh + 1);
    chk(ss ? "R8 cs span" : "R1 cs span", csLow, ss ? expSt : tTot);
    if (ss) chk("R8 cs outside strobe", csBad, 0);
    chk("R7 addr/bank/rnw held", addrBad, 0);
    chk("R11 ready low while busy", readyBad, 0);
    if (wr) chk("R10 write bus", busBad, 0);
    else    chk("R9 read data", int'(rdCap), int'(rdExp));
    @(negedge clk);
    chk("R11 done single", int'(done), 0);
    for (int i = 0; i < 6; i++) begin
      if (i > 0) @(negedge clk);
      if (intrude) chk("R11 no access from busy request", int'(memCsN), 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R12 reset values
    chk("R12 cs", int'(memCsN), 1);
    chk("R12 oe", int'(memOeN), 1);
    chk("R12 we", int'(memWeN), 1);
    chk("R12 done", int'(done), 0);
    rstN = 1'b1;
    @(negedge clk);
    chk("R12 ready", int'(reqReady), 1);
    chk("R12 cs after", int'(memCsN), 1);

    // base sweep, wait handling off
    for (int wr = 0; wr < 2; wr++)
      for (int rs = 0; rs < 3; rs++)
        for (int st = 0; st < 4; st++)
          for (int rh = 0; rh < 3; rh++)
            runAccess(wr[0], rs, st, rh, 0, 0, 0, 0, 0, 0, wr ? "R3 strobe" : "R2 strobe");

    // R6: wait pin asserted but handling off
    for (int wr = 0; wr < 2; wr++) begin
      runAccess(wr[0], 1, 4, 1, 0, 0, 1, 0, 8, 0, "R6 strobe");
      runAccess(wr[0], 2, 3, 0, 0, 0, 1, -2, 6, 0, "R6 strobe");
    end

    // R4/R5: sweep wait rise across the strobe window
    for (int wr = 0; wr < 2; wr++)
      for (int si = 0; si < 3; si++)
        for (int a = -1; a < 7; a++)
          for (int wi = 0; wi < 3; wi++) begin
            int st;
            int w;
            st = (si == 0) ? 3 : ((si == 1) ? 5 : 6);
            w  = (wi == 0) ? 1 : ((wi == 1) ? 2 : 4);
            if (a < st)
              runAccess(wr[0], 1, st, 1, 1, 0, 1, a, a + w, 0, (w == 1) ? "R5 strobe" : "R4 strobe");
          end

    // R8: select-strobe mode
    for (int wr = 0; wr < 2; wr++)
      for (int rs = 1; rs < 3; rs++)
        for (int rh = 0; rh < 3; rh++)
          runAccess(wr[0], rs, 1 + rh, rh, 0, 1, 0, 0, 0, 0, "R8 strobe");
    runAccess(1'b0, 1, 4, 1, 1, 1, 1, 0, 6, 0, "R8 strobe stretched");

    // R11: request held high while busy
    runAccess(1'b0, 1, 2, 1, 0, 0, 0, 0, 0, 1, "R11 strobe");
    runAccess(1'b1, 2, 3, 2, 0, 0, 0, 0, 0, 1, "R11 strobe");

    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  end
endmodule